// File: doc/BRIEF.md
# Serial Configuration Daisy-Chain Port

This block sits at the serial loading edge of a device that takes its configuration from an external bit clock and a single data line and passes data on to further devices wired behind it. On every rising edge of `clk` it samples `din`. It hunts for a fixed preamble and reads the length count that follows. It then absorbs that many bits as its own configuration, checks each frame against a serial CRC, and after that forwards all later data to the next device in the chain.

The controller is a five-state machine:
- `ST_SEEK` leaves for `ST_LENGTH` on a preamble match.
- `ST_LENGTH` leaves for `ST_LOAD` after the last length bit, or for `ST_FORWARD` when the count is zero.
- `ST_LOAD` leaves for `ST_FAULT` on a wrong check bit, or for `ST_FORWARD` after the last own bit.
- `ST_FORWARD` and `ST_FAULT` hold until reset.

`dout` repeats `din` one cycle late in `ST_SEEK`, `ST_LENGTH` and `ST_FORWARD`, and stays high in `ST_LOAD` and `ST_FAULT`. `init_n` models an open-drain error line and is low once a check fails. `done` rises when the device's own load has finished cleanly.

Top module: `cfg_chain_port`

## Requirements
- R1: After a synchronous reset, `dout` is 1, `init_n` is 1, `done` is 0, and the block is searching for the preamble.
- R2: `din` is sampled on the rising edge of `clk`. A header is recognised only when the 16 most recent bits, oldest first, equal 0xB26C. The 24 bits that follow form the length count, most significant bit first.
- R3: In the cycle after each bit sampled during the search or during the length field, `dout` equals that bit.
- R4: The length count gives the number of own bits that follow the header. In the cycle after each own bit is sampled, `dout` is 1.
- R5: Own bits form frames of 8 data bits followed by 4 check bits. The check bits are the remainder of the data polynomial times x^4, divided by x^4+x+1, sent most significant bit first. The remainder restarts at zero for each frame.
- R6: A wrong check bit drives `init_n` low from the next cycle on. `init_n` then stays low and `done` stays 0. Loading stops, and `dout` stays 1 for all later bits.
- R7: In the cycle after the last own bit of an error-free load, `done` becomes 1 and stays 1. Every later bit is echoed on `dout` one cycle late.
- R8: A length count of zero goes straight to forwarding and raises `done` in the cycle after the last length bit.
- R9: A reset in any state, including mid-load and after a fault or completion, clears `done` and the error, and a new header can then be loaded.
- R10: A length count that is not a multiple of 12 ends the load at the counted bit, even in the middle of a frame's data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration bit clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data out to the next device in the chain |
| init_n | output | 1 | Error flag, low after a check failure |
| done | output | 1 | High once this device's own load has completed cleanly |

## Verification
The assertions assume that `din` changes only away from the rising edge and is never unknown once reset has been released. They also assume that reset is held for at least one edge before any property is evaluated. The bench keeps to this: it changes `din` on the falling edge only, and it starts every case with several reset cycles. Each case begins with an idle run of ones, so the preamble can only be seen where the bench places it.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

    typedef enum logic [2:0] {
        ST_SEEK,
        ST_LENGTH,
        ST_LOAD,
        ST_FORWARD,
        ST_FAULT
    } chain_state_t;

endpackage

// File: rtl/cfg_crc_serial.sv
module cfg_crc_serial #(
    parameter int          W    = 4,
    parameter logic [W-1:0] POLY = 4'h3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);

    logic [W-1:0] rem_q;
    logic         fb;

    assign fb = rem_q[W-1] ^ bit_i;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rem_q <= '0;
        end else if (en) begin
            rem_q <= {rem_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    assign crc_o = rem_q;

    // R5: each frame starts from a zero remainder
    a_r5_crc_restart: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_o == '0));

endmodule

// File: rtl/cfg_load_counter.sv
module cfg_load_counter #(
    parameter int LEN_W = 24,
    parameter int FRM_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    output logic [LEN_W-1:0]         own_cnt_o,
    output logic [$clog2(FRM_W)-1:0] pos_o,
    output logic                     pos_last_o
);

    localparam int POS_W = $clog2(FRM_W);
    localparam logic [POS_W-1:0] POS_END = POS_W'(FRM_W - 1);

    logic [LEN_W-1:0] cnt_q;
    logic [POS_W-1:0] pos_q;

    assign pos_last_o = (pos_q == POS_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pos_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + LEN_W'(1);
            pos_q <= pos_last_o ? '0 : pos_q + POS_W'(1);
        end
    end

    assign own_cnt_o = cnt_q;
    assign pos_o     = pos_q;

    // R5: frame position never leaves the frame
    a_r5_pos_range: assert property (@(posedge clk) disable iff (rst)
        pos_q <= POS_END);

    // R4: the own-bit count only moves while loading
    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));

endmodule

// File: rtl/cfg_header_rx.sv
module cfg_header_rx #(
    parameter int               PRE_W    = 16,
    parameter int               LEN_W    = 24,
    parameter logic [PRE_W-1:0] PREAMBLE = 16'hB26C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seek_i,
    input  logic             len_en_i,
    input  logic             bit_i,
    output logic             pre_hit_o,
    output logic [LEN_W-1:0] len_o,
    output logic [LEN_W-1:0] len_next_o,
    output logic             len_last_o
);

    localparam int CNT_W = $clog2(LEN_W);

    logic [PRE_W-1:0] pre_sh;
    logic [LEN_W-1:0] len_sh;
    logic [CNT_W-1:0] len_cnt;

    assign pre_hit_o  = seek_i && ({pre_sh[PRE_W-2:0], bit_i} == PREAMBLE);
    assign len_next_o = {len_sh[LEN_W-2:0], bit_i};
    assign len_last_o = len_en_i && (len_cnt == CNT_W'(LEN_W - 1));
    assign len_o      = len_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_sh  <= '1;
            len_sh  <= '0;
            len_cnt <= '0;
        end else begin
            if (seek_i) begin
                pre_sh  <= {pre_sh[PRE_W-2:0], bit_i};
                len_cnt <= '0;
            end
            if (len_en_i) begin
                len_sh  <= len_next_o;
                len_cnt <= len_cnt + CNT_W'(1);
            end
        end
    end

    // R2: the length field has exactly LEN_W bits
    a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
        len_en_i |-> (len_cnt <= CNT_W'(LEN_W - 1)));

endmodule

// File: rtl/cfg_chain_port.sv
module cfg_chain_port #(
    parameter int               PRE_W    = 16,
    parameter int               LEN_W    = 24,
    parameter logic [PRE_W-1:0] PREAMBLE = 16'hB26C,
    parameter int               FRM_D    = 8,
    parameter int               CRC_W    = 4,
    parameter logic [CRC_W-1:0] CRC_POLY = 4'h3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic init_n,
    output logic done
);

    import cfg_chain_pkg::*;

    localparam int FRM_W = FRM_D + CRC_W;
    localparam int POS_W = $clog2(FRM_W);

    chain_state_t state_q, state_d;

    logic             pre_hit, len_last;
    logic [LEN_W-1:0] len_val, len_next;
    logic [LEN_W-1:0] own_cnt;
    logic [POS_W-1:0] pos;
    logic             pos_last;
    logic [CRC_W-1:0] crc;
    logic             in_load, chk_phase, chk_bit, chk_bad, own_last;
    logic             dout_q, err_q, done_q;

    assign in_load   = (state_q == ST_LOAD);
    assign chk_phase = (pos >= POS_W'(FRM_D));
    assign own_last  = (own_cnt == len_val - LEN_W'(1));
    assign chk_bad   = in_load && chk_phase && (din != chk_bit);

    always_comb begin
        chk_bit = crc[0];
        for (int i = 0; i < CRC_W; i++) begin
            if (pos == POS_W'(FRM_W - 1 - i)) chk_bit = crc[i];
        end
    end

    cfg_header_rx #(
        .PRE_W(PRE_W), .LEN_W(LEN_W), .PREAMBLE(PREAMBLE)
    ) hdr_i (
        .clk(clk), .rst(rst),
        .seek_i(state_q == ST_SEEK), .len_en_i(state_q == ST_LENGTH),
        .bit_i(din), .pre_hit_o(pre_hit), .len_o(len_val),
        .len_next_o(len_next), .len_last_o(len_last)
    );

    cfg_load_counter #(.LEN_W(LEN_W), .FRM_W(FRM_W)) cnt_i (
        .clk(clk), .rst(rst), .en(in_load),
        .own_cnt_o(own_cnt), .pos_o(pos), .pos_last_o(pos_last)
    );

    cfg_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) crc_i (
        .clk(clk), .rst(rst),
        .clr(in_load && pos_last), .en(in_load && !chk_phase),
        .bit_i(din), .crc_o(crc)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK:    if (pre_hit) state_d = ST_LENGTH;
            ST_LENGTH:  if (len_last) state_d = (len_next == '0) ? ST_FORWARD : ST_LOAD;
            ST_LOAD: begin
                if (chk_bad)       state_d = ST_FAULT;
                else if (own_last) state_d = ST_FORWARD;
            end
            ST_FORWARD: state_d = ST_FORWARD;
            ST_FAULT:   state_d = ST_FAULT;
            default:    state_d = ST_SEEK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEEK;
        else     state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= 1'b1;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SEEK, ST_LENGTH, ST_FORWARD: dout_q <= din;
                default:                        dout_q <= 1'b1;
            endcase
            if (state_d == ST_FAULT)                            err_q  <= 1'b1;
            if (state_d == ST_FORWARD && state_q != ST_FORWARD) done_q <= 1'b1;
        end
    end

    assign dout   = dout_q;
    assign init_n = ~err_q;
    assign done   = done_q;

    // R3: header bits are echoed one cycle later
    a_r3_hdr_echo: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LENGTH) |=> (dout == $past(din)));

    // R4: own bits are not passed downstream
    a_r4_load_high: assert property (@(posedge clk) disable iff (rst)
        in_load |=> dout);

    // R6: a fault is sticky and blocks completion
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        !init_n |=> (!init_n && !done && dout));

    // R7: completion is sticky and forwarding follows
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r7_fwd_echo: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FORWARD) |=> (dout == $past(din)));

endmodule

// File: tb/cfg_chain_port_tb.sv
module cfg_chain_port_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b1;
    logic dout, init_n, done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    localparam logic [15:0] PRE = 16'hB26C;

    always #2.5 clk = ~clk;

    cfg_chain_port dut_i (
        .clk(clk), .rst(rst), .din(din),
        .dout(dout), .init_n(init_n), .done(done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    // drive on falling edge, sample 1 ns after the rising edge
    task automatic send(logic b, logic exp_dout, string req);
        @(negedge clk);
        din = b;
        @(posedge clk);
        #1;
        chk(req, dout, exp_dout);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 dout", dout, 1'b1);
        chk("R1/R9 init_n", init_n, 1'b1);
        chk("R1/R9 done", done, 1'b0);
    endtask

    function automatic logic [7:0] dbyte(int fr, int salt);
        return 8'(fr * 53 + salt * 17 + 29);
    endfunction

    // remainder of d(x)*x^4 mod x^4+x+1 by long division
    function automatic logic [3:0] rem4(logic [7:0] d);
        logic [11:0] v = {d, 4'b0000};
        for (int i = 11; i >= 4; i--) begin
            if (v[i]) v = v ^ (12'b10011 << (i - 4));
        end
        return v[3:0];
    endfunction

    function automatic logic own_bit(int i, int salt);
        int pos = i % 12;
        int fr  = i / 12;
        logic [7:0] d = dbyte(fr, salt);
        logic [3:0] c = rem4(d);
        if (pos < 8) return d[7 - pos];
        return c[3 - (pos - 8)];
    endfunction

    task automatic send_header(int len);
        for (int k = 0; k < 4; k++) send(1'b1, 1'b1, "R3 idle echo");
        for (int k = 15; k >= 0; k--) send(PRE[k], PRE[k], "R2/R3 preamble echo");
        for (int k = 23; k >= 0; k--) begin
            logic b = 1'((len >> k) & 1);
            send(b, b, "R2/R3 length echo");
        end
    endtask

    task automatic run_case(int len, int bad, int salt);
        logic faulted = 1'b0;
        do_reset();
        send_header(len);
        for (int i = 0; i < len; i++) begin
            logic b = own_bit(i, salt);
            if (i == bad) b = ~b;
            send(b, 1'b1, faulted ? "R6 dout held" : "R4 own dout high");
            if (i == bad) faulted = 1'b1;
            chk(faulted ? "R6 init_n low" : "R5 init_n high", init_n, ~faulted);
        end
        chk(faulted ? "R6 no done" : (len == 0 ? "R8 done" : "R7 done"), done, ~faulted);
        for (int k = 0; k < 8; k++) begin
            logic b = 1'(k & 1);
            send(b, faulted ? 1'b1 : b, faulted ? "R6 no forward" : "R7 forward echo");
        end
        chk("R6/R7 final init_n", init_n, ~faulted);
        chk("R6/R7 final done", done, ~faulted);
    endtask

    initial begin
        // clean loads: whole frames, zero length and a partial last frame (R10)
        run_case(0, -1, 0);
        run_case(12, -1, 1);
        run_case(15, -1, 2);
        run_case(24, -1, 3);
        run_case(36, -1, 4);
        run_case(41, -1, 5);
        // corrupt every check bit of each frame of a 24-bit load (R6)
        for (int f = 0; f < 2; f++) begin
            for (int p = 8; p < 12; p++) run_case(24, f * 12 + p, 6 + p);
        end
        run_case(36, 35, 9);
        // R9: reset in the middle of a load, then a fresh load succeeds
        do_reset();
        send_header(24);
        for (int i = 0; i < 5; i++) send(own_bit(i, 1), 1'b1, "R9 pre-reset load");
        do_reset();
        for (int k = 0; k < 3; k++) send(1'(k & 1), 1'(k & 1), "R9 search echo after reset");
        run_case(24, -1, 11);
        // R9: reset after completion clears done
        do_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule